// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block keeps one queue's tally of finished instructions that asked to be reported, and decides when the completion interrupt line goes up. Every completion pulse that carries a request-interrupt flag adds one to the tally. Software acknowledges by writing how many completions it has consumed, and that amount is taken off the tally.

The interrupt is raised when either enough completions are pending or enough time has passed since the tally became nonzero. Time is measured by a free-running prescaler feeding a hold-off timer, so the time threshold counts in units of the prescale period. The timer is held at zero while nothing is pending. Every acknowledge and every direct load of the tally restarts the timer. The condition is then checked again against the new tally, so the line comes straight back if too many results are still outstanding. An enable bit with separate set and clear writes gates the line without stopping the counting.

Top module: `coal_irq_unit`

## Requirements
- R1: A completion pulse with its request flag set raises the tally by one on the next clock edge. A completion pulse with the flag clear leaves the tally unchanged.
- R2: An acknowledge write of N lowers the tally by N on the next edge, and stops at zero if N exceeds the tally. A flagged completion in the same cycle is applied after the subtraction. The tally is always readable on `done_cnt`, which is also the acknowledge read-back value.
- R3: A direct tally write loads the written value and takes precedence over any acknowledge or completion in the same cycle.
- R4: An increment at the all-ones tally value keeps the tally at all-ones.
- R5: While the tally is zero, the prescaler and the timer stay at zero, and the interrupt is low on the following cycle.
- R6: With the enable set, a tally at or above the count threshold drives the interrupt high on the next edge. A count threshold of zero acts as one.
- R7: With the enable set and a nonzero time threshold T, the interrupt rises once the tally has stayed nonzero without a restart for T×2^PRE_W clock edges. It is then registered one edge later. A time threshold of zero never triggers.
- R8: An acknowledge or a direct tally write clears the prescaler and the timer on the next edge. If the new tally still meets the count threshold, the interrupt stays high or is raised again at once.
- R9: Writing 1 on bit 0 of the enable-set port sets the enable, and writing 0 there changes nothing. Writing 1 on bit 0 of the enable-clear port clears it, and clear wins when both act in one cycle. `ena_rd` returns the enable. While the enable is clear the interrupt stays low, but counting and timing continue.
- R10: The wait register takes the count threshold from bits [19:0] and the time threshold from bits [47:32]. Read-back returns those fields with all other bits zero.
- R11: After reset, the tally, the interrupt, the enable and the wait register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_valid | input | 1 | One instruction finished this cycle |
| cmpl_irq_req | input | 1 | That instruction requested a completion interrupt |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_val | input | CNT_W | Number of completions acknowledged |
| cnt_we | input | 1 | Direct tally write strobe |
| cnt_val | input | CNT_W | Value loaded into the tally |
| wait_we | input | 1 | Wait register write strobe |
| wait_wdata | input | 48 | Wait register write data (count threshold [19:0], time threshold [47:32]) |
| ena_set_we | input | 1 | Enable-set write strobe |
| ena_set_bit | input | 1 | Enable-set data bit 0 |
| ena_clr_we | input | 1 | Enable-clear write strobe |
| ena_clr_bit | input | 1 | Enable-clear data bit 0 |
| done_cnt | output | CNT_W | Current tally (acknowledge read-back) |
| irq | output | 1 | Registered completion interrupt level |
| wait_rdata | output | 48 | Wait register read-back |
| ena_rd | output | 1 | Interrupt enable read-back |

## Verification
The bench builds the block with the full 20-bit tally and 16-bit time threshold, but with a 2-bit prescaler. A time threshold of a few units therefore expires within tens of cycles, so the time trigger, its disabling at zero and its restart on acknowledge are all exercised in directed runs. The tally's saturation edge is reached by a direct load just below all-ones, followed by flagged completions. A randomized stretch mixes completions, acknowledges larger than the tally, direct loads and enable toggles against the cycle model.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int unsigned WAIT_W   = 48;
  localparam int unsigned NUM_LSB  = 0;
  localparam int unsigned TIME_LSB = 32;
endpackage

// File: rtl/coal_count.sv
module coal_count #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ack_we,
  input  logic [CNT_W-1:0] ack_val,
  input  logic             ld_we,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] f_sub_sat(input logic [CNT_W-1:0] a,
                                                  input logic [CNT_W-1:0] b);
    return (b >= a) ? '0 : a - b;
  endfunction

  function automatic logic [CNT_W-1:0] f_inc_sat(input logic [CNT_W-1:0] a);
    return (a == CNT_MAX) ? a : a + 1'b1;
  endfunction

  logic [CNT_W-1:0] after_ack;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    after_ack = ack_we ? f_sub_sat(cnt_q, ack_val) : cnt_q;
    if (ld_we) cnt_nxt = ld_val;
    else       cnt_nxt = inc ? f_inc_sat(after_ack) : after_ack;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int unsigned TW_W  = 16,
  parameter int unsigned PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [PRE_W-1:0] pre_q,
  output logic [TW_W-1:0]  tmr_q
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};
  localparam logic [TW_W-1:0]  TMR_MAX = {TW_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else if (pre_q == PRE_MAX) begin
      pre_q <= '0;
      tmr_q <= (tmr_q == TMR_MAX) ? tmr_q : tmr_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/coal_cfg.sv
module coal_cfg
  import coal_pkg::*;
#(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned TW_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_we,
  input  logic [WAIT_W-1:0] wait_wdata,
  input  logic              set_we,
  input  logic              set_bit,
  input  logic              clr_we,
  input  logic              clr_bit,
  output logic [CNT_W-1:0]  num_q,
  output logic [TW_W-1:0]   time_q,
  output logic              ena_q,
  output logic [WAIT_W-1:0] wait_rdata
);
  localparam logic [WAIT_W-1:0] USED_MASK =
    (WAIT_W'({CNT_W{1'b1}}) << NUM_LSB) | (WAIT_W'({TW_W{1'b1}}) << TIME_LSB);

  logic unused_wait_bits;
  assign unused_wait_bits = ^(wait_wdata & ~USED_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q  <= '0;
      time_q <= '0;
      ena_q  <= 1'b0;
    end else begin
      if (wait_we) begin
        num_q  <= wait_wdata[NUM_LSB +: CNT_W];
        time_q <= wait_wdata[TIME_LSB +: TW_W];
      end
      if (clr_we && clr_bit)      ena_q <= 1'b0;
      else if (set_we && set_bit) ena_q <= 1'b1;
    end
  end

  assign wait_rdata = (WAIT_W'(num_q) << NUM_LSB) | (WAIT_W'(time_q) << TIME_LSB);
endmodule

// File: rtl/coal_irq_unit.sv
module coal_irq_unit
  import coal_pkg::*;
#(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned TW_W  = 16,
  parameter int unsigned PRE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl_valid,
  input  logic              cmpl_irq_req,
  input  logic              ack_we,
  input  logic [CNT_W-1:0]  ack_val,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              wait_we,
  input  logic [WAIT_W-1:0] wait_wdata,
  input  logic              ena_set_we,
  input  logic              ena_set_bit,
  input  logic              ena_clr_we,
  input  logic              ena_clr_bit,
  output logic [CNT_W-1:0]  done_cnt,
  output logic              irq,
  output logic [WAIT_W-1:0] wait_rdata,
  output logic              ena_rd
);
  function automatic logic f_fire(input logic [CNT_W-1:0] cnt,
                                  input logic [TW_W-1:0]  tmr,
                                  input logic [CNT_W-1:0] num,
                                  input logic [TW_W-1:0]  tw);
    logic [CNT_W-1:0] eff_num;
    eff_num = (num == '0) ? CNT_W'(1) : num;
    return (cnt != '0) && (((tw != '0) && (tmr >= tw)) || (cnt >= eff_num));
  endfunction

  logic             flagged_done;
  logic             timer_clr;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [TW_W-1:0]  scaled_time;
  logic [CNT_W-1:0] num_q;
  logic [TW_W-1:0]  time_q;
  logic             ena_q;
  logic             fire_now;
  logic             irq_q;

  assign flagged_done = cmpl_valid & cmpl_irq_req;
  assign timer_clr    = ack_we | cnt_we | (cnt_q == '0);

  coal_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (flagged_done),
    .ack_we (ack_we),
    .ack_val(ack_val),
    .ld_we  (cnt_we),
    .ld_val (cnt_val),
    .cnt_q  (cnt_q)
  );

  coal_timer #(.TW_W(TW_W), .PRE_W(PRE_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(timer_clr),
    .pre_q(pre_cnt),
    .tmr_q(scaled_time)
  );

  coal_cfg #(.CNT_W(CNT_W), .TW_W(TW_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_we   (wait_we),
    .wait_wdata(wait_wdata),
    .set_we    (ena_set_we),
    .set_bit   (ena_set_bit),
    .clr_we    (ena_clr_we),
    .clr_bit   (ena_clr_bit),
    .num_q     (num_q),
    .time_q    (time_q),
    .ena_q     (ena_q),
    .wait_rdata(wait_rdata)
  );

  assign fire_now = f_fire(cnt_q, scaled_time, num_q, time_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= ena_q & fire_now;
  end

  assign done_cnt = cnt_q;
  assign irq      = irq_q;
  assign ena_rd   = ena_q;
endmodule

// File: rtl/coal_irq_checker.sv
module coal_irq_checker
  import coal_pkg::*;
#(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned TW_W  = 16,
  parameter int unsigned PRE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmpl_valid,
  input logic              cmpl_irq_req,
  input logic              ack_we,
  input logic [CNT_W-1:0]  ack_val,
  input logic              cnt_we,
  input logic [CNT_W-1:0]  cnt_val,
  input logic [CNT_W-1:0]  done_cnt,
  input logic              irq,
  input logic [WAIT_W-1:0] wait_rdata,
  input logic              ena_rd,
  input logic [PRE_W-1:0]  pre_cnt,
  input logic [TW_W-1:0]   scaled_time
);
  logic [CNT_W-1:0] thr;
  assign thr = (wait_rdata[NUM_LSB +: CNT_W] == '0) ? CNT_W'(1) : wait_rdata[NUM_LSB +: CNT_W];

  assert_flag_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && cmpl_irq_req && !ack_we && !cnt_we && done_cnt != {CNT_W{1'b1}})
      |=> done_cnt == $past(done_cnt) + 1'b1);

  assert_noflag_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && !cmpl_irq_req && !ack_we && !cnt_we) |=> $stable(done_cnt));

  assert_ack_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !cnt_we && !cmpl_valid && ack_val >= done_cnt) |=> done_cnt == '0);

  assert_direct_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> done_cnt == $past(cnt_val));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_cnt == '0) |=> (!irq && pre_cnt == '0 && scaled_time == '0));

  assert_count_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_rd && done_cnt != '0 && done_cnt >= thr) |=> irq);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we || cnt_we) |=> (pre_cnt == '0 && scaled_time == '0));

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_rd |=> !irq);
endmodule

bind coal_irq_unit coal_irq_checker #(.CNT_W(CNT_W), .TW_W(TW_W), .PRE_W(PRE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmpl_valid  (cmpl_valid),
  .cmpl_irq_req(cmpl_irq_req),
  .ack_we      (ack_we),
  .ack_val     (ack_val),
  .cnt_we      (cnt_we),
  .cnt_val     (cnt_val),
  .done_cnt    (done_cnt),
  .irq         (irq),
  .wait_rdata  (wait_rdata),
  .ena_rd      (ena_rd),
  .pre_cnt     (pre_cnt),
  .scaled_time (scaled_time)
);

// File: tb/coal_irq_unit_bench.sv
module coal_irq_unit_bench;
  localparam int CNT_W = 20;
  localparam int TW_W  = 16;
  localparam int PRE_W = 2;
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam int TMAX  = (1 << TW_W) - 1;
  localparam int PMAX  = (1 << PRE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmpl_valid = 0, cmpl_irq_req = 0;
  logic              ack_we = 0, cnt_we = 0, wait_we = 0;
  logic [CNT_W-1:0]  ack_val = '0, cnt_val = '0;
  logic [47:0]       wait_wdata = '0;
  logic              ena_set_we = 0, ena_set_bit = 0, ena_clr_we = 0, ena_clr_bit = 0;
  logic [CNT_W-1:0]  done_cnt;
  logic              irq;
  logic [47:0]       wait_rdata;
  logic              ena_rd;

  always #5 clk = ~clk;

  coal_irq_unit #(.CNT_W(CNT_W), .TW_W(TW_W), .PRE_W(PRE_W)) u_coal_irq_unit (
    .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_irq_req(cmpl_irq_req),
    .ack_we(ack_we), .ack_val(ack_val), .cnt_we(cnt_we), .cnt_val(cnt_val),
    .wait_we(wait_we), .wait_wdata(wait_wdata), .ena_set_we(ena_set_we),
    .ena_set_bit(ena_set_bit), .ena_clr_we(ena_clr_we), .ena_clr_bit(ena_clr_bit),
    .done_cnt(done_cnt), .irq(irq), .wait_rdata(wait_rdata), .ena_rd(ena_rd)
  );

  int checks = 0, failures = 0;
  int m_cnt = 0, m_pre = 0, m_tmr = 0, m_num = 0, m_tw = 0;
  bit m_ena = 0, m_irq = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " done_cnt"}, done_cnt, m_cnt);
    chk({tag, " irq"}, irq, m_irq);
    chk({tag, " ena_rd"}, ena_rd, m_ena);
    chk({tag, " wait_rdata"}, wait_rdata, (longint'(m_tw) << 32) | longint'(m_num));
  endtask

  // behavioural next state from the inputs presently applied
  task automatic model_step();
    int  eff, c;
    bit  fire;
    eff  = (m_num == 0) ? 1 : m_num;
    fire = (m_cnt != 0) && (((m_tw != 0) && (m_tmr >= m_tw)) || (m_cnt >= eff));
    if (ack_we || cnt_we || m_cnt == 0) begin
      m_pre = 0; m_tmr = 0;
    end else if (m_pre == PMAX) begin
      m_pre = 0; if (m_tmr < TMAX) m_tmr++;
    end else m_pre++;
    if (cnt_we) c = int'(cnt_val);
    else begin
      c = m_cnt;
      if (ack_we) c = (int'(ack_val) >= c) ? 0 : c - int'(ack_val);
      if (cmpl_valid && cmpl_irq_req && c < CMAX) c++;
    end
    m_irq = m_ena && fire;
    m_cnt = c;
    if (wait_we) begin
      m_num = int'(wait_wdata[19:0]);
      m_tw  = int'(wait_wdata[47:32]);
    end
    if (ena_clr_we && ena_clr_bit) m_ena = 0;
    else if (ena_set_we && ena_set_bit) m_ena = 1;
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(negedge clk);
    compare(tag);
    cmpl_valid = 0; cmpl_irq_req = 0; ack_we = 0; cnt_we = 0; wait_we = 0;
    ena_set_we = 0; ena_set_bit = 0; ena_clr_we = 0; ena_clr_bit = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic done_pulse(input bit flag, input string tag);
    cmpl_valid = 1; cmpl_irq_req = flag; cyc(tag);
  endtask

  task automatic set_wait(input int tw, input int num, input string tag);
    wait_we = 1; wait_wdata = {tw[15:0], 12'hFA5, num[19:0]}; cyc(tag);
  endtask

  initial begin
    int wd = 0;
    while (!done_flag) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R11 reset state");

    // R10 layout, junk in middle bits dropped
    set_wait(3, 5, "R10 wait write");
    chk("R10 readback", wait_rdata, 48'h0003_0000_0005);

    // R9 enable set/clear
    ena_set_we = 1; ena_set_bit = 0; cyc("R9 set with zero");
    chk("R9 no effect", ena_rd, 0);
    ena_set_we = 1; ena_set_bit = 1; cyc("R9 set");
    ena_set_we = 1; ena_set_bit = 1; ena_clr_we = 1; ena_clr_bit = 1; cyc("R9 clear wins");
    chk("R9 clear wins", ena_rd, 0);
    ena_set_we = 1; ena_set_bit = 1; cyc("R9 set again");

    // R1 flagged / unflagged completions
    for (int i = 0; i < 3; i++) done_pulse(1, "R1 flagged");
    chk("R1 count three", done_cnt, 3);
    for (int i = 0; i < 2; i++) done_pulse(0, "R1 unflagged");
    chk("R1 unflagged ignored", done_cnt, 3);

    // R7 time trigger (T=3, prescale 4)
    idle(20, "R7 time wait");
    chk("R7 fired", irq, 1);

    // R8 restart on acknowledge
    ack_we = 1; ack_val = 1; cyc("R8 ack restarts");
    idle(3, "R8 after ack");
    chk("R8 dropped", irq, 0);
    set_wait(3, 2, "R8 lower threshold");
    idle(2, "R8 count refire");
    ack_we = 1; ack_val = 0; cyc("R8 ack zero");
    idle(2, "R8 stays high");
    chk("R8 still high", irq, 1);

    // R2 saturating ack with same-cycle completion
    ack_we = 1; ack_val = 10; cmpl_valid = 1; cmpl_irq_req = 1; cyc("R2 ack over count");
    chk("R2 floor plus one", done_cnt, 1);
    ack_we = 1; ack_val = 5; cyc("R2 ack to zero");

    // R5 idle with nothing pending
    idle(15, "R5 quiet");
    chk("R5 irq low", irq, 0);

    // R6 zero threshold acts as one, time disabled
    set_wait(0, 0, "R6 cfg");
    done_pulse(1, "R6 single");
    idle(2, "R6 fire");
    chk("R6 fired", irq, 1);

    // R9 gating: counting continues
    ena_clr_we = 1; ena_clr_bit = 1; cyc("R9 disable");
    done_pulse(1, "R9 counts while gated");
    idle(10, "R9 gated");
    chk("R9 gated low", irq, 0);
    ena_set_we = 1; ena_set_bit = 1; cyc("R9 reenable");
    idle(2, "R9 back");

    // R7 zero time threshold never fires
    set_wait(0, 100, "R7 disable time");
    idle(60, "R7 no time trigger");
    chk("R7 disabled", irq, 0);

    // R3 direct load wins, R4 saturation
    cnt_we = 1; cnt_val = CMAX - 1; ack_we = 1; ack_val = 7;
    cmpl_valid = 1; cmpl_irq_req = 1; cyc("R3 load wins");
    chk("R3 loaded", done_cnt, CMAX - 1);
    for (int i = 0; i < 3; i++) done_pulse(1, "R4 saturate");
    chk("R4 at max", done_cnt, CMAX);

    // mixed random traffic
    set_wait(2, 6, "R2 mixed cfg");
    cnt_we = 1; cnt_val = 0; cyc("R3 clear");
    for (int i = 0; i < 2000; i++) begin
      cmpl_valid   = ($urandom % 3) == 0;
      cmpl_irq_req = ($urandom % 4) != 0;
      ack_we       = ($urandom % 10) == 0;
      ack_val      = CNT_W'($urandom % 5);
      cnt_we       = ($urandom % 97) == 0;
      cnt_val      = CNT_W'($urandom % 9);
      ena_set_we   = ($urandom % 40) == 0; ena_set_bit = 1'($urandom);
      ena_clr_we   = ($urandom % 60) == 0; ena_clr_bit = 1'($urandom);
      if (($urandom % 300) == 0) begin
        wait_we = 1;
        wait_wdata = {16'($urandom % 4), 12'h0, 20'($urandom % 8)};
      end
      cyc("R2 mixed");
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule